// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a single-port synchronous static memory with a 36-bit word made of four 9-bit lanes. All control inputs are captured on the rising clock edge. An access is opened by one of two active-low address strobes, one for a processor and one for a controller. It is accepted only when the three chip-select inputs together decode as selected. Once an access is open, each later clock with no strobe continues it. The low two address bits then come from an internal burst counter that steps when the advance input is low.

Write control is decoded from a global-write input, a byte-write enable and four per-lane selects. The global write takes priority over byte writes. Read data is registered and leaves through an output-enable gate. The bidirectional bus is split into separate input, output and output-valid signals, so the block can be synthesized. A small parameterised array stands in for the full-size memory.

Top module: `burst_sram`

## Requirements
- R1: At a clock where either strobe opens an access, the block is selected only if cs1_n=0, cs2=1 and cs3_n=0. Otherwise no lane is written, no read is made, and later clocks without a strobe make no access.
- R2: When cs1_n=1, a low strobe_p_n has no effect. An open burst continues exactly as if no strobe were present.
- R3: An access opened by the processor strobe is always a read. Write inputs in that cycle change no lane.
- R4: When gwrite_n=0, all four lanes are written from din, whatever the values of bwen_n and lane_sel_n.
- R5: When gwrite_n=1 and bwen_n=0, lane k (din bits 9k+8 down to 9k) is written only when lane_sel_n[k]=0. The other lanes keep their contents.
- R6: When gwrite_n=1 and bwen_n=1, the cycle is a read and no lane changes, whatever lane_sel_n is.
- R7: In a continuation cycle with adv_n=0, the low two address bits step by one and wrap from 3 to 0, and the upper bits stay fixed. With adv_n=1 the address is repeated.
- R8: Data read in the cycle captured at a rising edge is on dout with dout_vld=1 right after that edge.
- R9: oe_n acts without a clock. While it is 1, dout_vld is 0 and dout is all zeros.
- R10: The data of the first read after a deselected state (including after reset) is masked, and dout_vld stays 0 for it.
- R11: While reset is asserted, dout_vld is 0 and dout is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, taken when a strobe opens an access |
| cs1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwrite_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not valid |
| dout_vld | output | 1 | Read data is being driven |

## Verification
The assertions take for granted that inputs are stable around the clock edge. They also assume that both strobes are never low together in a selected cycle, so each write-decode property sees a single opening source. The bench drives every input two time units after the rising edge. It never lowers both strobes in the same selected cycle. It toggles oe_n only between edges, so the clocked checks see settled values.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int BURST_BITS = 2;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/burst_sram_wdec.sv
module burst_sram_wdec #(
    parameter int LANES = 4
) (
    input  logic             gwrite_n,
    input  logic             bwen_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] lane_we
);

    // global write outranks the byte path
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_we[k] = !gwrite_n || (!bwen_n && !lane_sel_n[k]);
    end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              strobe_p_n,
    input  logic              strobe_c_n,
    input  logic              adv_n,
    input  logic [LANES-1:0]  lane_we,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  wr_lanes,
    output logic              rd_en,
    output logic              active_q,
    output logic              rd_vld_q,
    output logic              mask_q
);

    localparam int HI_W = ADDR_W - BURST_BITS;

    typedef struct packed {
        logic                  active;
        logic [HI_W-1:0]       hi;
        logic [BURST_BITS-1:0] ctr;
        logic                  rd_vld;
        logic                  mask;
    } state_t;

    state_t            st_d, st_q;
    logic              selected;
    logic              p_start;
    logic              c_start;
    logic              acc;
    logic              wr_ok;
    logic [ADDR_W-1:0] eff;
    logic [LANES-1:0]  wmask;
    acc_kind_e         kind;

    always_comb begin
        st_d     = st_q;
        selected = !cs1_n && cs2 && !cs3_n;
        p_start  = !strobe_p_n && !cs1_n;
        c_start  = !strobe_c_n;
        acc      = 1'b0;
        wr_ok    = 1'b0;
        eff      = {st_q.hi, st_q.ctr};

        if (p_start || c_start) begin
            if (selected) begin
                acc         = 1'b1;
                wr_ok       = !p_start;
                eff         = addr;
                st_d.active = 1'b1;
            end else begin
                st_d.active = 1'b0;
            end
        end else if (st_q.active) begin
            acc   = 1'b1;
            wr_ok = 1'b1;
            eff   = {st_q.hi, st_q.ctr + {{(BURST_BITS-1){1'b0}}, !adv_n}};
        end

        wmask = (acc && wr_ok) ? lane_we : '0;
        if (!acc)
            kind = ACC_NONE;
        else if (|wmask)
            kind = ACC_WRITE;
        else
            kind = ACC_READ;

        if (acc) begin
            st_d.hi  = eff[ADDR_W-1:BURST_BITS];
            st_d.ctr = eff[BURST_BITS-1:0];
        end
        st_d.rd_vld = (kind == ACC_READ);
        st_d.mask   = (kind == ACC_READ) && !st_q.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign acc_addr = eff;
    assign wr_lanes = wmask;
    assign rd_en    = (kind == ACC_READ);
    assign active_q = st_q.active;
    assign rd_vld_q = st_q.rd_vld;
    assign mask_q   = st_q.mask;

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  logic [LANES-1:0]          wr_lanes,
    input  logic                      rd_en,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_d, rd_q;

        always_ff @(posedge clk) begin
            if (wr_lanes[k])
                mem[acc_addr] <= wdata[k*LANE_W +: LANE_W];
        end

        always_comb begin
            rd_d = rd_q;
            if (rd_en)
                rd_d = mem[acc_addr];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rd_q <= '0;
            else
                rd_q <= rd_d;
        end

        assign rdata[k*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    strobe_p_n,
    input  logic                    strobe_c_n,
    input  logic                    adv_n,
    input  logic                    gwrite_n,
    input  logic                    bwen_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_vld
);

    logic [LANES-1:0]        lane_we;
    logic [LANES-1:0]        wr_lanes;
    logic [ADDR_W-1:0]       acc_addr;
    logic                    rd_en;
    logic                    active_q;
    logic                    rd_vld_q;
    logic                    mask_q;
    logic [LANES*LANE_W-1:0] rdata;

    burst_sram_wdec #(.LANES(LANES)) u_wdec (
        .gwrite_n   (gwrite_n),
        .bwen_n     (bwen_n),
        .lane_sel_n (lane_sel_n),
        .lane_we    (lane_we)
    );

    burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .cs1_n      (cs1_n),
        .cs2        (cs2),
        .cs3_n      (cs3_n),
        .strobe_p_n (strobe_p_n),
        .strobe_c_n (strobe_c_n),
        .adv_n      (adv_n),
        .lane_we    (lane_we),
        .acc_addr   (acc_addr),
        .wr_lanes   (wr_lanes),
        .rd_en      (rd_en),
        .active_q   (active_q),
        .rd_vld_q   (rd_vld_q),
        .mask_q     (mask_q)
    );

    burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_addr (acc_addr),
        .wr_lanes (wr_lanes),
        .rd_en    (rd_en),
        .wdata    (din),
        .rdata    (rdata)
    );

    // output gate: asynchronous enable, masked on the first read out of deselect
    assign dout_vld = rd_vld_q && !oe_n && !mask_q;
    assign dout     = dout_vld ? rdata : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cs1_n,
    input logic                    cs2,
    input logic                    cs3_n,
    input logic                    strobe_p_n,
    input logic                    strobe_c_n,
    input logic                    adv_n,
    input logic                    gwrite_n,
    input logic                    bwen_n,
    input logic [LANES-1:0]        lane_sel_n,
    input logic                    oe_n,
    input logic [LANES*LANE_W-1:0] dout,
    input logic                    dout_vld,
    input logic [LANES-1:0]        wr_lanes,
    input logic                    rd_en,
    input logic [ADDR_W-1:0]       acc_addr,
    input logic                    active_q
);

    logic sel_in, open_any, c_only;
    assign sel_in   = !cs1_n && cs2 && !cs3_n;
    assign open_any = !strobe_c_n || (!strobe_p_n && !cs1_n);
    assign c_only   = !strobe_c_n && strobe_p_n && sel_in;

    p_no_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (open_any && !sel_in) |-> (wr_lanes == '0 && !rd_en));

    p_stay_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (open_any && !sel_in) |=> !active_q);

    p_pstrobe_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !strobe_p_n && cs1_n && strobe_c_n) |-> (rd_en || wr_lanes != '0));

    p_pstart_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_p_n && sel_in) |-> (wr_lanes == '0 && rd_en));

    p_global_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_only && !gwrite_n) |-> (wr_lanes == '1));

    p_byte_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_only && gwrite_n && !bwen_n) |-> (wr_lanes == ~lane_sel_n));

    p_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_only && gwrite_n && bwen_n) |-> (wr_lanes == '0));

    p_step_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && strobe_c_n && (strobe_p_n || cs1_n) && !adv_n)
        |-> (acc_addr[1:0] == 2'($past(acc_addr[1:0]) + 2'd1)));

    p_hold_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && strobe_c_n && (strobe_p_n || cs1_n))
        |-> (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])));

    p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_vld);

    p_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> (dout == '0));

    p_first_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && !$past(active_q)) |-> !dout_vld);

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs1_n      (cs1_n),
    .cs2        (cs2),
    .cs3_n      (cs3_n),
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .adv_n      (adv_n),
    .gwrite_n   (gwrite_n),
    .bwen_n     (bwen_n),
    .lane_sel_n (lane_sel_n),
    .oe_n       (oe_n),
    .dout       (dout),
    .dout_vld   (dout_vld),
    .wr_lanes   (wr_lanes),
    .rd_en      (rd_en),
    .acc_addr   (acc_addr),
    .active_q   (active_q)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;

    localparam int AW = 6;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          cs1_n, cs2, cs3_n, strobe_p_n, strobe_c_n, adv_n;
    logic          gwrite_n, bwen_n, oe_n;
    logic [3:0]    lane_sel_n;
    logic [DW-1:0] din, dout;
    logic          dout_vld;

    logic [DW-1:0] mm [64];
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 1'b0;

    always #10 clk = ~clk;

    burst_sram u_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
        .adv_n(adv_n), .gwrite_n(gwrite_n), .bwen_n(bwen_n),
        .lane_sel_n(lane_sel_n), .oe_n(oe_n), .din(din), .dout(dout),
        .dout_vld(dout_vld)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        strobe_p_n = 1'b1; strobe_c_n = 1'b1; adv_n = 1'b1;
        gwrite_n = 1'b1; bwen_n = 1'b1; lane_sel_n = 4'hF;
    endtask

    task automatic sel_on();
        cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
    endtask

    task automatic deselect();
        idle();
        cs1_n = 1'b0; cs2 = 1'b0; cs3_n = 1'b0; strobe_c_n = 1'b0;
        step();
        strobe_c_n = 1'b1;
    endtask

    task automatic wr_global(input logic [AW-1:0] a, input logic [DW-1:0] d);
        sel_on(); strobe_c_n = 1'b0; gwrite_n = 1'b0; bwen_n = 1'b0;
        lane_sel_n = 4'hF; addr = a; din = d;
        step();
        mm[a] = d;
        deselect();
    endtask

    // R10 first read masked, R8 second read visible
    task automatic read_chk(input logic [AW-1:0] a, input string tag);
        sel_on(); strobe_p_n = 1'b0; addr = a;
        step();
        chk(dout_vld == 1'b0, "R10 first read masked", {35'd0, dout_vld}, '0);
        strobe_p_n = 1'b1; adv_n = 1'b1;
        step();
        chk(dout_vld && dout == mm[a], tag, dout, mm[a]);
        deselect();
        chk(dout_vld == 1'b0, "R1 no output after deselect", {35'd0, dout_vld}, '0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(); cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1; oe_n = 1'b0; addr = '0; din = '0;
        repeat (3) step();
        chk(dout_vld == 1'b0 && dout == '0, "R11 reset state", dout, '0);
        rst_n = 1'b1;
        step();
        chk(dout_vld == 1'b0 && dout == '0, "R11 after release", dout, '0);
    endtask

    task automatic t_global();
        for (int i = 0; i < 16; i++) wr_global(AW'(i), 36'h5_0000_0000 + 36'(i * 36'h0_0101_0101));
        read_chk(6'd3, "R4 global write with lane selects high");
        read_chk(6'd15, "R8 registered read data");
    endtask

    task automatic t_byte();
        logic [DW-1:0] exp;
        wr_global(6'd5, 36'h0_0000_0000);
        sel_on(); strobe_c_n = 1'b0; gwrite_n = 1'b1; bwen_n = 1'b0;
        lane_sel_n = 4'b1010; addr = 6'd5; din = 36'hF_FFFF_FFFF;
        step();
        exp = mm[5];
        for (int k = 0; k < 4; k++)
            if (!lane_sel_n[k]) exp[k*9 +: 9] = din[k*9 +: 9];
        mm[5] = exp;
        deselect();
        read_chk(6'd5, "R5 lanes 0 and 2 only");
    endtask

    task automatic t_nowrite();
        sel_on(); strobe_c_n = 1'b0; gwrite_n = 1'b1; bwen_n = 1'b1;
        lane_sel_n = 4'h0; addr = 6'd14; din = 36'h0_DEAD_BEEF;
        step();
        strobe_c_n = 1'b1; lane_sel_n = 4'h0;
        step();
        chk(dout_vld && dout == mm[14], "R6 no write without enables", dout, mm[14]);
        deselect();
        read_chk(6'd14, "R6 contents kept");
    endtask

    task automatic t_pstart();
        sel_on(); strobe_p_n = 1'b0; gwrite_n = 1'b0; addr = 6'd13; din = 36'h1_2345_6789;
        step();
        gwrite_n = 1'b1; strobe_p_n = 1'b1; adv_n = 1'b1;
        step();
        chk(dout_vld && dout == mm[13], "R3 processor start ignores write", dout, mm[13]);
        deselect();
        read_chk(6'd13, "R3 contents kept");
    endtask

    task automatic t_burst();
        sel_on(); strobe_p_n = 1'b0; addr = 6'd10;
        step();
        chk(dout_vld == 1'b0, "R10 burst start masked", {35'd0, dout_vld}, '0);
        strobe_p_n = 1'b1; adv_n = 1'b0;
        for (int i = 1; i < 4; i++) begin
            step();
            chk(dout_vld && dout == mm[8 + ((2 + i) % 4)], "R7 linear wrap", dout, mm[8 + ((2 + i) % 4)]);
        end
        adv_n = 1'b1;
        step();
        chk(dout_vld && dout == mm[9], "R7 hold without advance", dout, mm[9]);
        deselect();
    endtask

    task automatic t_pignore();
        sel_on(); strobe_c_n = 1'b0; addr = 6'd8;
        step();
        strobe_c_n = 1'b1; cs1_n = 1'b1; strobe_p_n = 1'b0; addr = 6'd20; adv_n = 1'b0;
        step();
        chk(dout_vld && dout == mm[9], "R2 processor strobe gated by cs1_n", dout, mm[9]);
        deselect();
    endtask

    task automatic t_deselect();
        sel_on(); cs3_n = 1'b1; strobe_c_n = 1'b0; gwrite_n = 1'b0; addr = 6'd12; din = 36'h0_0BAD_0BAD;
        step();
        chk(dout_vld == 1'b0, "R1 deselected cycle", {35'd0, dout_vld}, '0);
        idle();
        step();
        chk(dout_vld == 1'b0, "R1 no continuation", {35'd0, dout_vld}, '0);
        read_chk(6'd12, "R1 write blocked");
    endtask

    task automatic t_oe();
        sel_on(); strobe_p_n = 1'b0; addr = 6'd9;
        step();
        strobe_p_n = 1'b1; adv_n = 1'b1;
        step();
        oe_n = 1'b1; #1;
        chk(dout_vld == 1'b0 && dout == '0, "R9 oe high disables", dout, '0);
        oe_n = 1'b0; #1;
        chk(dout_vld && dout == mm[9], "R9 oe low restores", dout, mm[9]);
        deselect();
    endtask

    initial begin
        t_reset();
        t_global();
        t_byte();
        t_nowrite();
        t_pstart();
        t_burst();
        t_pignore();
        t_deselect();
        t_oe();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule